// File: doc/BRIEF.md
# Serial EEPROM SPI Slave Front End

This block is the serial front end of an SPI-attached EEPROM. It runs on a fast system clock and oversamples the chip-select, serial clock, serial input and pause pins. The pins are expected to arrive already synchronised to that clock. Bus modes 0 and 3 are both accepted. Input bits are captured on rising SCK, output bits change on falling SCK, and every field travels most significant bit first. A frame opens with one command byte. Address and data bytes follow as that command requires.

The block does not hold the memory array, the protection policy, the status register or the programming timer. Instead it issues single-cycle requests to those neighbours: set or clear the write-enable latch, fetch an array byte, deposit a byte into the page buffer, commit the page, and load a new status value. It takes back the busy flag, the latch state, the status byte and the fetched data. The serial output is always driven. A separate enable tells the pad when to drive it, and the pad floats the line otherwise.

A pause pin can freeze a frame part-way through. The transfer then resumes exactly where it stopped, with no need to resend anything.

Top module: `eep_spi_slave`

## Requirements
- R1: The command byte is decoded with bit 3 ignored and bits 7..4 required to be zero. Low three bits 110 pulse `set_wel`, 100 pulse `clr_wel`, 101 select status read, 001 status write, 011 array read and 010 array write.
- R2: A command byte that does not decode produces no request for the rest of the frame, and `so_en` stays low until chip select has gone high and low again.
- R3: An array read takes 16 address bits after the command, of which only the low `ADDR_W` are used. On the last address bit it pulses `rd_req` with that address, and the fetched byte leaves on `so` MSB first, one bit per falling SCK.
- R4: A read keeps streaming. On the fall that sends bit 0 of each byte it requests the next address, and the address wraps from the top of the array to 0.
- R5: A status read sends `status_in` repeatedly for as long as clocks continue, sampling it again at the start of every byte.
- R6: An array write accepted with `wel` high takes a 16-bit address. Each full data byte pulses `wr_valid` with the current address and the byte. Only the low `PAGE_W` address bits advance, wrapping inside the page, and the upper bits stay fixed.
- R7: An array write command received while `wel` is low is ignored, with no deposit and no commit.
- R8: When chip select rises after a write (array or status) that carried at least one whole data byte and ends on a byte boundary, `wr_commit` or `wrsr_valid` is pulsed, the latter with the last byte received. A frame ending mid-byte commits nothing.
- R9: While `busy` is high, only the status read is accepted. Every other command is treated as undecodable.
- R10: The pause state follows the inverse of `holdn` only while SCK is low and chip select is low, and keeps its value while SCK is high. While paused, SCK edges are ignored and `so_en` is low.
- R11: `so_en` is low whenever chip select is high or the frame is not in a data-out phase. Chip select high resets the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| csn | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| holdn | input | 1 | Pause request, active low |
| so | output | 1 | Serial data out |
| so_en | output | 1 | Pad drive enable for `so` |
| busy | input | 1 | Programming cycle in progress |
| wel | input | 1 | Write-enable latch state |
| status_in | input | 8 | Status byte to return |
| rd_req | output | 1 | Array fetch strobe |
| rd_addr | output | ADDR_W | Array fetch address |
| rd_data | input | 8 | Fetched byte, valid the cycle after `rd_req` |
| wr_valid | output | 1 | Page buffer deposit strobe |
| wr_addr | output | ADDR_W | Deposit address |
| wr_data | output | 8 | Deposit byte |
| wr_commit | output | 1 | Start programming the page |
| wrsr_valid | output | 1 | Load new status value |
| wrsr_data | output | 8 | New status value |
| set_wel | output | 1 | Set the write-enable latch |
| clr_wel | output | 1 | Clear the write-enable latch |

## Verification
The case that needs care is the rising edge of chip select. In that one cycle the frame is reset, and the same cycle also decides whether a write is committed, based on how many bits the frame carried. Write frames are therefore ended once exactly on a byte boundary and once a few bits past it. The bench expects a commit only in the first case, while the deposits of the whole bytes still appear in both. A second coincidence is the fall that sends a read's last bit, which must also fetch the next address. This is provoked by streaming across the top of the array and by pausing mid-byte, and each received byte is compared with the bench's memory image.

// File: rtl/eep_spi_pkg.sv
package eep_spi_pkg;

   typedef enum logic [2:0] {
      CMD_NONE,
      CMD_WEN_SET,
      CMD_WEN_CLR,
      CMD_STAT_RD,
      CMD_STAT_WR,
      CMD_ARR_RD,
      CMD_ARR_WR
   } cmd_e;

   typedef enum logic [2:0] {
      PH_OPC,
      PH_ADDR,
      PH_DIN,
      PH_DOUT,
      PH_SKIP
   } phase_e;

   localparam int unsigned BYTE_W   = 8;
   localparam int unsigned AFIELD_W = 16;

   // bit 3 is ignored; upper nibble must be clear
   function automatic cmd_e decode_op(input logic [7:0] b);
      cmd_e c;
      c = CMD_NONE;
      if (b[7:4] == 4'h0) begin
         case (b[2:0])
            3'b110:  c = CMD_WEN_SET;
            3'b100:  c = CMD_WEN_CLR;
            3'b101:  c = CMD_STAT_RD;
            3'b001:  c = CMD_STAT_WR;
            3'b011:  c = CMD_ARR_RD;
            3'b010:  c = CMD_ARR_WR;
            default: c = CMD_NONE;
         endcase
      end
      return c;
   endfunction

endpackage

// File: rtl/eep_spi_pins.sv
module eep_spi_pins #(
   parameter bit HOLD_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic csn,
   input  logic sck,
   input  logic holdn,
   output logic sck_rise,
   output logic sck_fall,
   output logic cs_rise,
   output logic held
);

   logic sck_q;
   logic csn_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q <= 1'b0;
         csn_q <= 1'b1;
      end else begin
         sck_q <= sck;
         csn_q <= csn;
      end
   end

   generate
      if (HOLD_EN) begin : g_hold
         // pause state only moves while the serial clock is low
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    held <= 1'b0;
            else if (csn)  held <= 1'b0;
            else if (!sck) held <= ~holdn;
         end
      end else begin : g_no_hold
         assign held = 1'b0;
      end
   endgenerate

   assign sck_rise = ~csn &  sck & ~sck_q & ~held;
   assign sck_fall = ~csn & ~sck &  sck_q & ~held;
   assign cs_rise  =  csn & ~csn_q;

endmodule

// File: rtl/eep_spi_frame.sv
module eep_spi_frame
   import eep_spi_pkg::*;
#(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned PAGE_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csn,
   input  logic              sck_rise,
   input  logic              sck_fall,
   input  logic              cs_rise,
   input  logic              si,
   input  logic              busy,
   input  logic              wel,
   input  logic [7:0]        status_in,
   input  logic [7:0]        rd_data,
   output logic              so_q,
   output logic              dout_phase,
   output logic              set_wel,
   output logic              clr_wel,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              wr_valid,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        wr_data,
   output logic              wr_commit,
   output logic              wrsr_valid,
   output logic [7:0]        wrsr_data
);

   localparam int unsigned SH_W  = ADDR_W - 1;
   localparam int unsigned HI_W  = ADDR_W - PAGE_W;
   localparam int unsigned CNT_W = $clog2(AFIELD_W);

   phase_e            phase;
   cmd_e              kind;
   cmd_e              dec;
   logic [SH_W-1:0]   sh;
   logic [CNT_W-1:0]  bitcnt;
   logic [2:0]        ocnt;
   logic [7:0]        out_sh;
   logic [1:0]        pend;
   logic              got_byte;
   logic [ADDR_W-1:0] ptr;
   logic [7:0]        wrsr_q;
   logic [7:0]        byte_in;
   logic [ADDR_W-1:0] addr_in;

   assign byte_in    = {sh[6:0], si};
   assign addr_in    = {sh, si};
   assign dout_phase = (phase == PH_DOUT);
   assign wrsr_data  = wrsr_q;

   always_comb begin
      dec = decode_op(byte_in);
      if (busy && dec != CMD_STAT_RD) dec = CMD_NONE;
      if (dec == CMD_ARR_WR && !wel)  dec = CMD_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= PH_OPC;
         kind       <= CMD_NONE;
         sh         <= '0;
         bitcnt     <= '0;
         ocnt       <= '0;
         out_sh     <= '0;
         pend       <= '0;
         got_byte   <= 1'b0;
         ptr        <= '0;
         wrsr_q     <= '0;
         so_q       <= 1'b0;
         set_wel    <= 1'b0;
         clr_wel    <= 1'b0;
         rd_req     <= 1'b0;
         rd_addr    <= '0;
         wr_valid   <= 1'b0;
         wr_addr    <= '0;
         wr_data    <= '0;
         wr_commit  <= 1'b0;
         wrsr_valid <= 1'b0;
      end else begin
         set_wel    <= 1'b0;
         clr_wel    <= 1'b0;
         rd_req     <= 1'b0;
         wr_valid   <= 1'b0;
         wr_commit  <= 1'b0;
         wrsr_valid <= 1'b0;
         pend       <= {pend[0], 1'b0};
         if (pend[1]) out_sh <= rd_data;

         if (cs_rise && phase == PH_DIN && bitcnt[2:0] == 3'd0 && got_byte) begin
            if (kind == CMD_ARR_WR) wr_commit  <= 1'b1;
            else                    wrsr_valid <= 1'b1;
         end

         if (csn) begin
            phase    <= PH_OPC;
            kind     <= CMD_NONE;
            bitcnt   <= '0;
            got_byte <= 1'b0;
            pend     <= '0;
         end else if (sck_rise) begin
            sh <= addr_in[SH_W-1:0];
            case (phase)
               PH_OPC: begin
                  if (bitcnt == CNT_W'(7)) begin
                     bitcnt <= '0;
                     kind   <= dec;
                     case (dec)
                        CMD_WEN_SET: begin set_wel <= 1'b1; phase <= PH_SKIP; end
                        CMD_WEN_CLR: begin clr_wel <= 1'b1; phase <= PH_SKIP; end
                        CMD_STAT_RD: begin out_sh <= status_in; ocnt <= '0; phase <= PH_DOUT; end
                        CMD_STAT_WR: phase <= PH_DIN;
                        CMD_ARR_RD,
                        CMD_ARR_WR:  phase <= PH_ADDR;
                        default:     phase <= PH_SKIP;
                     endcase
                  end else begin
                     bitcnt <= bitcnt + CNT_W'(1);
                  end
               end
               PH_ADDR: begin
                  if (bitcnt == CNT_W'(AFIELD_W - 1)) begin
                     bitcnt <= '0;
                     if (kind == CMD_ARR_RD) begin
                        rd_addr <= addr_in;
                        rd_req  <= 1'b1;
                        pend    <= 2'b01;
                        ocnt    <= '0;
                        phase   <= PH_DOUT;
                     end else begin
                        ptr   <= addr_in;
                        phase <= PH_DIN;
                     end
                  end else begin
                     bitcnt <= bitcnt + CNT_W'(1);
                  end
               end
               PH_DIN: begin
                  bitcnt <= {{(CNT_W-3){1'b0}}, bitcnt[2:0] + 3'd1};
                  if (bitcnt[2:0] == 3'd7) begin
                     got_byte <= 1'b1;
                     if (kind == CMD_ARR_WR) begin
                        wr_valid <= 1'b1;
                        wr_addr  <= ptr;
                        wr_data  <= byte_in;
                        ptr      <= {ptr[ADDR_W-1 -: HI_W], ptr[PAGE_W-1:0] + PAGE_W'(1)};
                     end else begin
                        wrsr_q <= byte_in;
                     end
                  end
               end
               default: ;
            endcase
         end else if (sck_fall && phase == PH_DOUT) begin
            so_q   <= out_sh[7];
            out_sh <= {out_sh[6:0], 1'b0};
            ocnt   <= ocnt + 3'd1;
            if (ocnt == 3'd7) begin
               if (kind == CMD_ARR_RD) begin
                  rd_addr <= rd_addr + ADDR_W'(1);
                  rd_req  <= 1'b1;
                  pend    <= 2'b01;
               end else begin
                  out_sh <= status_in;
               end
            end
         end
      end
   end

endmodule

// File: rtl/eep_spi_slave.sv
module eep_spi_slave
   import eep_spi_pkg::*;
#(
   parameter int unsigned ADDR_W  = 12,
   parameter int unsigned PAGE_W  = 5,
   parameter bit          HOLD_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csn,
   input  logic              sck,
   input  logic              si,
   input  logic              holdn,
   output logic              so,
   output logic              so_en,
   input  logic              busy,
   input  logic              wel,
   input  logic [7:0]        status_in,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [7:0]        rd_data,
   output logic              wr_valid,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        wr_data,
   output logic              wr_commit,
   output logic              wrsr_valid,
   output logic [7:0]        wrsr_data,
   output logic              set_wel,
   output logic              clr_wel
);

   if (ADDR_W < 8 || ADDR_W > AFIELD_W) begin : g_bad_addr_w
      $error("eep_spi_slave: ADDR_W must lie in 8..16");
   end
   if (PAGE_W < 1 || PAGE_W >= ADDR_W) begin : g_bad_page_w
      $error("eep_spi_slave: PAGE_W must lie in 1..ADDR_W-1");
   end

   logic sck_rise;
   logic sck_fall;
   logic cs_rise;
   logic held;
   logic dout_phase;

   eep_spi_pins #(
      .HOLD_EN (HOLD_EN)
   ) i_pins (
      .clk      (clk),
      .rst_n    (rst_n),
      .csn      (csn),
      .sck      (sck),
      .holdn    (holdn),
      .sck_rise (sck_rise),
      .sck_fall (sck_fall),
      .cs_rise  (cs_rise),
      .held     (held)
   );

   eep_spi_frame #(
      .ADDR_W (ADDR_W),
      .PAGE_W (PAGE_W)
   ) i_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .csn        (csn),
      .sck_rise   (sck_rise),
      .sck_fall   (sck_fall),
      .cs_rise    (cs_rise),
      .si         (si),
      .busy       (busy),
      .wel        (wel),
      .status_in  (status_in),
      .rd_data    (rd_data),
      .so_q       (so),
      .dout_phase (dout_phase),
      .set_wel    (set_wel),
      .clr_wel    (clr_wel),
      .rd_req     (rd_req),
      .rd_addr    (rd_addr),
      .wr_valid   (wr_valid),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .wr_commit  (wr_commit),
      .wrsr_valid (wrsr_valid),
      .wrsr_data  (wrsr_data)
   );

   assign so_en = dout_phase & ~held & ~csn;

endmodule

// File: rtl/eep_spi_slave_chk.sv
module eep_spi_slave_chk #(
   parameter int unsigned ADDR_W  = 12,
   parameter int unsigned PAGE_W  = 5,
   parameter bit          HOLD_EN = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              csn,
   input logic              sck,
   input logic              holdn,
   input logic              so,
   input logic              so_en,
   input logic              busy,
   input logic              held,
   input logic              set_wel,
   input logic              clr_wel,
   input logic              rd_req,
   input logic              wr_valid,
   input logic              wr_commit,
   input logic              wrsr_valid,
   input logic [ADDR_W-1:0] wr_addr
);

   logic [ADDR_W-1:0] last_wa;
   logic              last_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_wa <= '0;
         last_ok <= 1'b0;
      end else if (csn) begin
         last_ok <= 1'b0;
      end else if (wr_valid) begin
         last_ok <= 1'b1;
         last_wa <= wr_addr;
      end
   end

   a_r1_single_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({set_wel, clr_wel, rd_req, wr_valid, wr_commit, wrsr_valid}));

   a_r11_idle_float: assert property (@(posedge clk) disable iff (!rst_n)
      csn |-> !so_en);

   a_r3_so_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (!csn && $past(csn) == 1'b0 && so != $past(so)) |->
      ($past(sck) == 1'b0 && $past(sck, 2) == 1'b1));

   a_r9_busy_lockout: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !(set_wel || clr_wel || rd_req || wr_valid || wr_commit || wrsr_valid));

   a_r10_hold_floats: assert property (@(posedge clk) disable iff (!rst_n)
      held |-> !so_en);

   a_r6_page_step: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && last_ok) |->
      (wr_addr[PAGE_W-1:0] == last_wa[PAGE_W-1:0] + PAGE_W'(1)) &&
      (wr_addr[ADDR_W-1:PAGE_W] == last_wa[ADDR_W-1:PAGE_W]));

   if (HOLD_EN) begin : g_hold_chk
      a_r10_hold_sample: assert property (@(posedge clk) disable iff (!rst_n)
         (!sck && !csn) |=> (held == !$past(holdn)));
   end

endmodule

bind eep_spi_slave eep_spi_slave_chk #(
   .ADDR_W  (ADDR_W),
   .PAGE_W  (PAGE_W),
   .HOLD_EN (HOLD_EN)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .csn        (csn),
   .sck        (sck),
   .holdn      (holdn),
   .so         (so),
   .so_en      (so_en),
   .busy       (busy),
   .held       (held),
   .set_wel    (set_wel),
   .clr_wel    (clr_wel),
   .rd_req     (rd_req),
   .wr_valid   (wr_valid),
   .wr_commit  (wr_commit),
   .wrsr_valid (wrsr_valid),
   .wr_addr    (wr_addr)
);

// File: tb/test_eep_spi_slave.sv
module test_eep_spi_slave;
   localparam int AW = 12;
   localparam int PW = 5;
   localparam int HP = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic csn = 1'b1;
   logic sck = 1'b0;
   logic si = 1'b0;
   logic holdn = 1'b1;
   logic busy = 1'b0;
   logic wel = 1'b0;
   logic [7:0] status_in = 8'h00;
   logic [7:0] rd_data = 8'h00;
   logic so, so_en, rd_req, wr_valid, wr_commit, wrsr_valid, set_wel, clr_wel;
   logic [AW-1:0] rd_addr, wr_addr;
   logic [7:0] wr_data, wrsr_data;

   eep_spi_slave #(.ADDR_W(AW), .PAGE_W(PW), .HOLD_EN(1'b1)) i_eep_spi_slave (
      .clk(clk), .rst_n(rst_n), .csn(csn), .sck(sck), .si(si), .holdn(holdn),
      .so(so), .so_en(so_en), .busy(busy), .wel(wel), .status_in(status_in),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
      .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
      .wr_commit(wr_commit), .wrsr_valid(wrsr_valid), .wrsr_data(wrsr_data),
      .set_wel(set_wel), .clr_wel(clr_wel)
   );

   always #10 clk = ~clk;

   logic [7:0] mem [0:4095];
   always @(posedge clk) if (rd_req) rd_data <= mem[rd_addr];

   int nvec = 0;
   int nbad = 0;
   int exp_q[$];
   int obs_q[$];
   bit done = 1'b0;
   logic mode3 = 1'b0;

   function automatic int pk(input int t, input int a, input int d);
      return (t << 24) | (a << 8) | d;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      nvec++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // request monitor and per-clock idle check (R11)
   always @(negedge clk) begin
      if (rst_n) begin
         if (set_wel)    obs_q.push_back(pk(1, 0, 0));
         if (clr_wel)    obs_q.push_back(pk(2, 0, 0));
         if (rd_req)     obs_q.push_back(pk(3, int'(rd_addr), 0));
         if (wr_valid)   obs_q.push_back(pk(4, int'(wr_addr), int'(wr_data)));
         if (wr_commit)  obs_q.push_back(pk(5, 0, 0));
         if (wrsr_valid) obs_q.push_back(pk(6, 0, int'(wrsr_data)));
         if (csn) chk("R11 idle so_en", int'(so_en), 0);
      end
   end

   task automatic check_events(input string req);
      chk({req, " request count"}, obs_q.size(), exp_q.size());
      if (obs_q.size() == exp_q.size())
         foreach (exp_q[i]) chk({req, " request"}, obs_q[i], exp_q[i]);
      obs_q.delete();
      exp_q.delete();
   endtask

   task automatic cs_lo();
      sck = mode3;
      repeat (HP) @(negedge clk);
      csn = 1'b0;
      repeat (HP) @(negedge clk);
   endtask

   task automatic cs_hi();
      if (!mode3) begin
         sck = 1'b0;
         repeat (HP) @(negedge clk);
      end
      csn = 1'b1;
      repeat (2*HP) @(negedge clk);
   endtask

   task automatic bitx(input logic b, output logic o);
      sck = 1'b0;
      si  = b;
      repeat (HP) @(negedge clk);
      o   = so;
      sck = 1'b1;
      repeat (HP) @(negedge clk);
   endtask

   task automatic bytex(input logic [7:0] tx, output logic [7:0] rx);
      logic o;
      for (int i = 7; i >= 0; i--) begin
         bitx(tx[i], o);
         rx[i] = o;
      end
   endtask

   initial begin
      logic [7:0] r;
      logic [7:0] r2;
      logic o;
      for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 7 + 3);
      repeat (3) @(negedge clk);
      chk("R11 reset so_en", int'(so_en), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 latch commands, mode 0 and mode 3, bit 3 ignored
      cs_lo(); bytex(8'h06, r); cs_hi();
      exp_q.push_back(pk(1, 0, 0)); check_events("R1 set latch");
      mode3 = 1'b1;
      cs_lo(); bytex(8'h0E, r); cs_hi();
      exp_q.push_back(pk(1, 0, 0)); check_events("R1 set latch bit3");
      cs_lo(); bytex(8'h04, r); cs_hi();
      exp_q.push_back(pk(2, 0, 0)); check_events("R1 clear latch");
      mode3 = 1'b0;

      // R2 undecodable command then read-like bytes
      cs_lo(); bytex(8'h16, r); bytex(8'h03, r);
      chk("R2 so_en after bad command", int'(so_en), 0);
      bytex(8'h00, r); bytex(8'h10, r);
      chk("R2 so_en later", int'(so_en), 0);
      cs_hi(); check_events("R2 no requests");

      // R3 read with don't-care upper address and bit 3 set, R4 streaming
      cs_lo(); bytex(8'h0B, r); bytex(8'hF1, r); bytex(8'h23, r);
      bytex(8'h00, r); chk("R3 first byte", r, mem[12'h123]);
      chk("R11 so_en in data out", int'(so_en), 1);
      bytex(8'h00, r); chk("R4 second byte", r, mem[12'h124]);
      bytex(8'h00, r); chk("R4 third byte", r, mem[12'h125]);
      cs_hi();
      for (int a = 'h123; a <= 'h126; a++) exp_q.push_back(pk(3, a, 0));
      check_events("R3 fetch");

      // R4 wrap at top, mode 3
      mode3 = 1'b1;
      cs_lo(); bytex(8'h03, r); bytex(8'h0F, r); bytex(8'hFF, r);
      bytex(8'h00, r); chk("R4 top byte", r, mem[12'hFFF]);
      bytex(8'h00, r); chk("R4 wrapped byte", r, mem[12'h000]);
      cs_hi();
      exp_q.push_back(pk(3, 'hFFF, 0)); exp_q.push_back(pk(3, 0, 0)); exp_q.push_back(pk(3, 1, 0));
      check_events("R4 wrap fetch");
      mode3 = 1'b0;

      // R5 status repeats, resampled per byte
      status_in = 8'h8C;
      cs_lo(); bytex(8'h05, r);
      bytex(8'h00, r); chk("R5 status 0", r, 8'h8C);
      status_in = 8'h5A;
      bytex(8'h00, r); chk("R5 status 1", r, 8'h8C);
      bytex(8'h00, r); chk("R5 status 2", r, 8'h5A);
      cs_hi(); check_events("R5 no requests");

      // R7 write without latch
      wel = 1'b0;
      cs_lo(); bytex(8'h02, r); bytex(8'h00, r); bytex(8'h40, r); bytex(8'h11, r);
      chk("R7 so_en", int'(so_en), 0);
      cs_hi(); check_events("R7 ignored write");

      // R6 page wrap and R8 commit
      wel = 1'b1;
      cs_lo(); bytex(8'h02, r); bytex(8'h0A, r); bytex(8'h3E, r);
      bytex(8'hAA, r); bytex(8'hBB, r); bytex(8'hCC, r);
      cs_hi();
      exp_q.push_back(pk(4, 'hA3E, 'hAA)); exp_q.push_back(pk(4, 'hA3F, 'hBB));
      exp_q.push_back(pk(4, 'hA20, 'hCC)); exp_q.push_back(pk(5, 0, 0));
      check_events("R6 page write");

      // R8 partial byte: deposits but no commit
      cs_lo(); bytex(8'h02, r); bytex(8'h01, r); bytex(8'h00, r); bytex(8'h55, r);
      bitx(1'b1, o); bitx(1'b0, o); bitx(1'b1, o);
      cs_hi();
      exp_q.push_back(pk(4, 'h100, 'h55));
      check_events("R8 partial write");

      // R8 status write, whole and partial
      cs_lo(); bytex(8'h01, r); bytex(8'h8C, r); cs_hi();
      exp_q.push_back(pk(6, 0, 'h8C)); check_events("R8 status write");
      cs_lo(); bytex(8'h01, r);
      for (int i = 0; i < 4; i++) bitx(1'b1, o);
      cs_hi(); check_events("R8 partial status write");

      // R9 busy lockout
      busy = 1'b1;
      cs_lo(); bytex(8'h06, r); cs_hi(); check_events("R9 latch while busy");
      cs_lo(); bytex(8'h03, r); bytex(8'h00, r); bytex(8'h10, r); bytex(8'h00, r);
      chk("R9 read while busy so_en", int'(so_en), 0);
      cs_hi(); check_events("R9 read while busy");
      status_in = 8'hFF;
      cs_lo(); bytex(8'h05, r); bytex(8'h00, r); chk("R9 status while busy", r, 8'hFF);
      cs_hi(); check_events("R9 status no requests");
      busy = 1'b0;

      // R10 pause mid-byte during a read
      cs_lo(); bytex(8'h03, r); bytex(8'h02, r); bytex(8'h00, r);
      for (int i = 7; i >= 5; i--) begin bitx(1'b0, o); r2[i] = o; end
      sck = 1'b0;
      repeat (HP) @(negedge clk);
      holdn = 1'b0;
      repeat (HP) @(negedge clk);
      chk("R10 so_en paused", int'(so_en), 0);
      for (int k = 0; k < 3; k++) begin
         sck = 1'b1; si = 1'b1;
         repeat (HP) @(negedge clk);
         sck = 1'b0;
         repeat (HP) @(negedge clk);
      end
      chk("R10 so_en still paused", int'(so_en), 0);
      holdn = 1'b1;
      repeat (HP) @(negedge clk);
      for (int i = 4; i >= 0; i--) begin bitx(1'b0, o); r2[i] = o; end
      chk("R10 byte across pause", r2, mem[12'h200]);
      bytex(8'h00, r); chk("R10 byte after pause", r, mem[12'h201]);
      cs_hi();
      for (int a = 'h200; a <= 'h202; a++) exp_q.push_back(pk(3, a, 0));
      check_events("R10 fetch");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nbad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end

endmodule